// File: doc/BRIEF.md
# Memory Card Transaction Error Detector

This block follows a single command, response and data exchange with a serial memory card and raises sticky error flags. It sits beside the card serializer. From that serializer it receives the response bits or bytes, the start of read data, the verdict of the data CRC engine, the write status token and the level of the data line. It checks the response CRC7 itself. The response length and whether a CRC is present both depend on the response format that is latched when the command starts.

Two wait windows are counted in bus clock edges: one from the end of the command to the start of the response, and one from the end of the response to the start of read data. While the bus clock is stopped, no edges arrive and the counters hold. In SPI mode the response is a fixed number of bytes, and a read may begin with a one-byte error token in place of the start token. When SPI runs without CRC protection, CRC mismatches are not reported.

Software reads the flags once `done_o` is high. It can clear them with a one-cycle pulse, and any new command start also clears all of them.

Top module: `mmc_err_detect`

## Requirements
- R1: After reset, all six error flags, `done_o` and `busy_o` are 0.
- R2: In native mode, format 1 is a 48-bit response with CRC7 (x^7+x^3+1, zero seed) over bits 0..39, received CRC in bits 40..46 (MSB first) and an end bit at 47. Format 2 is a 136-bit response with CRC7 over bits 8..127, received CRC in bits 128..134 and an end bit at 135. A mismatch sets `rsp_crc_err_o`.
- R3: In native mode, format 3 has 48 bits and its CRC field is never checked.
- R4: In SPI mode, the response starts with the first byte whose bit 7 is 0. Formats 1, 2 and 3 take 1, 2 and 5 bytes respectively, and the response phase ends only after the last of them.
- R5: `rsp_to_err_o` sets when N bus ticks pass after command end with no response start, where N is `rsp_to_i`. A start that arrives on the Nth tick wins over the timeout. A timeout ends the sequence.
- R6: `rd_to_err_o` sets when `rd_to_i` bus ticks pass in the read-wait phase with no data start. A timeout ends the sequence.
- R7: A read CRC verdict with `rd_crc_ok_i` = 0 sets `rd_crc_err_o`.
- R8: A write status token of 3'b101 sets `wr_crc_err_o`.
- R9: After the write token, `busy_o` is 1 until `dat0_i` is sampled high. The sequence then ends.
- R10: In an SPI read, byte 0xFE starts the data, and 0xFF is ignored. A byte whose upper nibble is 0 is an error token: it sets `spi_tok_err_o` and ends the sequence.
- R11: In SPI mode with `crc_prot_i` = 0, a failed read CRC and a 3'b101 write token set no flag.
- R12: Flags are sticky. `err_clr_i` clears them, but a flag set in the same cycle as the clear wins. `cmd_start_i` clears all flags.
- R13: The timeout counters advance only on cycles where `bus_tick_i` is high.
- R14: `done_o` stays high from the end of a sequence until the next `cmd_start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_tick_i | input | 1 | One pulse per card bus clock edge |
| cmd_start_i | input | 1 | Starts a sequence, latches the configuration, clears flags |
| spi_mode_i | input | 1 | 1: SPI mode, 0: native mode |
| crc_prot_i | input | 1 | SPI CRC protection enable |
| rsp_fmt_i | input | 2 | 0 none, 1 short, 2 long, 3 short without CRC |
| xfer_i | input | 2 | 0 none, 1 read, 2 write |
| cmd_end_i | input | 1 | Last command bit has been sent |
| rsp_to_i | input | TO_W | Response timeout in bus ticks |
| rd_to_i | input | TO_W | Read timeout in bus ticks |
| rsp_bit_vld_i | input | 1 | Native response bit strobe |
| rsp_bit_i | input | 1 | Native response bit |
| rsp_byte_vld_i | input | 1 | SPI response byte strobe |
| rsp_byte_i | input | 8 | SPI response byte |
| rd_start_i | input | 1 | Native read data start bit seen |
| rd_byte_vld_i | input | 1 | SPI read byte strobe |
| rd_byte_i | input | 8 | SPI read byte |
| rd_crc_vld_i | input | 1 | Data CRC verdict strobe |
| rd_crc_ok_i | input | 1 | Data CRC matched |
| wr_tok_vld_i | input | 1 | Write status token strobe |
| wr_tok_i | input | 3 | Write status token code |
| dat0_i | input | 1 | Data line level, low means busy |
| err_clr_i | input | 1 | Clears all flags |
| rsp_crc_err_o | output | 1 | Response CRC error |
| rsp_to_err_o | output | 1 | Response timeout |
| rd_crc_err_o | output | 1 | Read data CRC error |
| rd_to_err_o | output | 1 | Read timeout |
| wr_crc_err_o | output | 1 | Write CRC status error |
| spi_tok_err_o | output | 1 | SPI read error token |
| done_o | output | 1 | Sequence finished |
| busy_o | output | 1 | Card holding data line busy |

## Verification
A response start bit can land on the same bus tick that uses up the response timeout. To provoke this, the bench sets the limit to five, issues four idle ticks, and then sends the first response bit together with the fifth tick. The expected result is a clean response with no timeout flag. A second run with five idle ticks must abort and raise only the timeout flag. Comparing the two runs shows that the limit is exact and that the start takes priority.

// File: rtl/mce_pkg.sv
package mce_pkg;
  localparam int unsigned ERR_W = 6;
  localparam int unsigned E_RSP_CRC = 0;
  localparam int unsigned E_RSP_TO  = 1;
  localparam int unsigned E_RD_CRC  = 2;
  localparam int unsigned E_RD_TO   = 3;
  localparam int unsigned E_WR_CRC  = 4;
  localparam int unsigned E_SPI_TOK = 5;

  localparam logic [1:0] FMT_NONE  = 2'd0;
  localparam logic [1:0] FMT_SHORT = 2'd1;
  localparam logic [1:0] FMT_LONG  = 2'd2;
  localparam logic [1:0] FMT_NOCRC = 2'd3;

  localparam logic [1:0] XF_NONE  = 2'd0;
  localparam logic [1:0] XF_READ  = 2'd1;
  localparam logic [1:0] XF_WRITE = 2'd2;

  // native response bit positions
  localparam int unsigned SHORT_CRC_END = 40;
  localparam int unsigned SHORT_LAST    = 47;
  localparam int unsigned LONG_CRC_BEG  = 8;
  localparam int unsigned LONG_CRC_END  = 128;
  localparam int unsigned LONG_LAST     = 135;
  localparam int unsigned CRC_LEN       = 7;

  localparam logic [6:0] CRC7_POLY   = 7'h09;
  localparam logic [2:0] TOK_CRC_BAD = 3'b101;
  localparam logic [7:0] SPI_IDLE    = 8'hFF;
  localparam logic [7:0] SPI_RD_GO   = 8'hFE;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_RSP, ST_RD_WAIT, ST_RD_DATA, ST_WR_TOK, ST_WR_BUSY, ST_DONE
  } seq_e;

  function automatic logic [2:0] spi_rsp_bytes(logic [1:0] fmt);
    case (fmt)
      FMT_LONG:  return 3'd2;
      FMT_NOCRC: return 3'd5;
      default:   return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/mce_crc7.sv
module mce_crc7
  import mce_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       bit_i,
  output logic [6:0] crc_o
);
  logic [6:0] crc_q;
  logic       fb;

  assign fb    = bit_i ^ crc_q[6];
  assign crc_o = crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '0;
    else if (clr_i)  crc_q <= '0;
    else if (en_i)   crc_q <= {crc_q[5:0], 1'b0} ^ (fb ? CRC7_POLY : 7'h00);
  end
endmodule

// File: rtl/mce_timer.sv
module mce_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  localparam int unsigned W = CNT_W + 1;
  logic [W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt  = cnt_q + W'(1);
  assign expire_o = run_i & tick_i & (cnt_nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (clr_i)                        cnt_q <= '0;
    else if (run_i && tick_i && !expire_o) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/mce_rsp_rx.sv
module mce_rsp_rx
  import mce_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       arm_i,
  input  logic       en_i,
  input  logic       spi_i,
  input  logic [1:0] fmt_i,
  input  logic       bit_vld_i,
  input  logic       bit_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       started_o,
  output logic       start_o,
  output logic       done_o,
  output logic       crc_bad_o
);
  logic             started_q;
  logic [IDX_W-1:0] idx_q, cur_idx, last_idx;
  logic [6:0]       rx_crc_q, calc_crc;
  logic             start_cond, unit, take, is_long;
  logic             crc_win, rx_win;
  logic [IDX_W-1:0] crc_beg, crc_end;

  assign is_long    = (fmt_i == FMT_LONG);
  assign start_cond = spi_i ? (byte_vld_i && byte_i != SPI_IDLE && !byte_i[7])
                            : (bit_vld_i && !bit_i);
  assign unit       = spi_i ? byte_vld_i : bit_vld_i;
  assign start_o    = en_i & ~started_q & start_cond;
  assign take       = en_i & (started_q ? unit : start_cond);
  assign cur_idx    = started_q ? idx_q : '0;
  assign started_o  = started_q;

  always_comb begin
    if (spi_i)        last_idx = IDX_W'(spi_rsp_bytes(fmt_i)) - IDX_W'(1);
    else if (is_long) last_idx = IDX_W'(LONG_LAST);
    else              last_idx = IDX_W'(SHORT_LAST);
    crc_beg = is_long ? IDX_W'(LONG_CRC_BEG) : '0;
    crc_end = is_long ? IDX_W'(LONG_CRC_END) : IDX_W'(SHORT_CRC_END);
  end

  assign crc_win   = take & ~spi_i & (cur_idx >= crc_beg) & (cur_idx < crc_end);
  assign rx_win    = take & ~spi_i & (cur_idx >= crc_end)
                   & (cur_idx < crc_end + IDX_W'(CRC_LEN));
  assign done_o    = take & (cur_idx == last_idx);
  assign crc_bad_o = done_o & ~spi_i & (fmt_i != FMT_NOCRC) & (rx_crc_q != calc_crc);

  mce_crc7 i_crc7 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (arm_i),
    .en_i   (crc_win),
    .bit_i  (bit_i),
    .crc_o  (calc_crc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      idx_q     <= '0;
      rx_crc_q  <= '0;
    end else if (arm_i) begin
      started_q <= 1'b0;
      idx_q     <= '0;
      rx_crc_q  <= '0;
    end else if (take) begin
      started_q <= 1'b1;
      idx_q     <= cur_idx + IDX_W'(1);
      if (rx_win) rx_crc_q <= {rx_crc_q[5:0], bit_i};
    end
  end
endmodule

// File: rtl/mmc_err_detect.sv
module mmc_err_detect
  import mce_pkg::*;
#(
  parameter int unsigned TO_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bus_tick_i,
  input  logic            cmd_start_i,
  input  logic            spi_mode_i,
  input  logic            crc_prot_i,
  input  logic [1:0]      rsp_fmt_i,
  input  logic [1:0]      xfer_i,
  input  logic            cmd_end_i,
  input  logic [TO_W-1:0] rsp_to_i,
  input  logic [TO_W-1:0] rd_to_i,
  input  logic            rsp_bit_vld_i,
  input  logic            rsp_bit_i,
  input  logic            rsp_byte_vld_i,
  input  logic [7:0]      rsp_byte_i,
  input  logic            rd_start_i,
  input  logic            rd_byte_vld_i,
  input  logic [7:0]      rd_byte_i,
  input  logic            rd_crc_vld_i,
  input  logic            rd_crc_ok_i,
  input  logic            wr_tok_vld_i,
  input  logic [2:0]      wr_tok_i,
  input  logic            dat0_i,
  input  logic            err_clr_i,
  output logic            rsp_crc_err_o,
  output logic            rsp_to_err_o,
  output logic            rd_crc_err_o,
  output logic            rd_to_err_o,
  output logic            wr_crc_err_o,
  output logic            spi_tok_err_o,
  output logic            done_o,
  output logic            busy_o
);
  localparam int unsigned N_TMR = 2;
  localparam int unsigned T_RSP = 0;
  localparam int unsigned T_RD  = 1;

  seq_e             state_q, state_d;
  logic             spi_q, prot_q;
  logic [1:0]       fmt_q, xf_q;
  logic [ERR_W-1:0] err_q, err_set;
  logic             crc_chk;
  seq_e             after_rsp;

  logic             rx_started, rx_start, rx_done, rx_crc_bad;
  logic [N_TMR-1:0] tmr_run, tmr_clr, tmr_exp;
  logic [TO_W-1:0]  tmr_lim [N_TMR];
  logic             rd_go, rd_errtok;

  assign crc_chk = ~spi_q | prot_q;

  always_comb begin
    case (xf_q)
      XF_READ:  after_rsp = ST_RD_WAIT;
      XF_WRITE: after_rsp = ST_WR_TOK;
      default:  after_rsp = ST_DONE;
    endcase
  end

  mce_rsp_rx #(.IDX_W(8)) i_rsp_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (state_q != ST_RSP),
    .en_i       (state_q == ST_RSP),
    .spi_i      (spi_q),
    .fmt_i      (fmt_q),
    .bit_vld_i  (rsp_bit_vld_i),
    .bit_i      (rsp_bit_i),
    .byte_vld_i (rsp_byte_vld_i),
    .byte_i     (rsp_byte_i),
    .started_o  (rx_started),
    .start_o    (rx_start),
    .done_o     (rx_done),
    .crc_bad_o  (rx_crc_bad)
  );

  assign tmr_run[T_RSP] = (state_q == ST_RSP) & ~rx_started;
  assign tmr_clr[T_RSP] = (state_q != ST_RSP);
  assign tmr_lim[T_RSP] = rsp_to_i;
  assign tmr_run[T_RD]  = (state_q == ST_RD_WAIT);
  assign tmr_clr[T_RD]  = (state_q != ST_RD_WAIT);
  assign tmr_lim[T_RD]  = rd_to_i;

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    mce_timer #(.CNT_W(TO_W)) i_tmr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (tmr_clr[g]),
      .run_i    (tmr_run[g]),
      .tick_i   (bus_tick_i),
      .limit_i  (tmr_lim[g]),
      .expire_o (tmr_exp[g])
    );
  end

  assign rd_errtok = rd_byte_vld_i & (rd_byte_i[7:4] == 4'h0);
  assign rd_go     = spi_q ? (rd_byte_vld_i & (rd_byte_i == SPI_RD_GO)) : rd_start_i;

  always_comb begin
    state_d = state_q;
    err_set = '0;
    case (state_q)
      ST_CMD:
        if (cmd_end_i) state_d = (fmt_q == FMT_NONE) ? after_rsp : ST_RSP;
      ST_RSP:
        if (rx_done) begin
          err_set[E_RSP_CRC] = rx_crc_bad;
          state_d = after_rsp;
        end else if (tmr_exp[T_RSP] && !rx_start) begin
          err_set[E_RSP_TO] = 1'b1;
          state_d = ST_DONE;
        end
      ST_RD_WAIT:
        if (rd_go) begin
          state_d = ST_RD_DATA;
        end else if (spi_q && rd_errtok) begin
          err_set[E_SPI_TOK] = 1'b1;
          state_d = ST_DONE;
        end else if (tmr_exp[T_RD]) begin
          err_set[E_RD_TO] = 1'b1;
          state_d = ST_DONE;
        end
      ST_RD_DATA:
        if (rd_crc_vld_i) begin
          err_set[E_RD_CRC] = ~rd_crc_ok_i & crc_chk;
          state_d = ST_DONE;
        end
      ST_WR_TOK:
        if (wr_tok_vld_i) begin
          err_set[E_WR_CRC] = (wr_tok_i == TOK_CRC_BAD) & crc_chk;
          state_d = ST_WR_BUSY;
        end
      ST_WR_BUSY:
        if (dat0_i) state_d = ST_DONE;
      default: ;
    endcase
    if (cmd_start_i) begin
      state_d = ST_CMD;
      err_set = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      spi_q   <= 1'b0;
      prot_q  <= 1'b0;
      fmt_q   <= FMT_NONE;
      xf_q    <= XF_NONE;
      err_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cmd_start_i) begin
        spi_q  <= spi_mode_i;
        prot_q <= crc_prot_i;
        fmt_q  <= rsp_fmt_i;
        xf_q   <= xfer_i;
        err_q  <= '0;
      end else begin
        err_q <= (err_clr_i ? '0 : err_q) | err_set;
      end
    end
  end

  assign rsp_crc_err_o = err_q[E_RSP_CRC];
  assign rsp_to_err_o  = err_q[E_RSP_TO];
  assign rd_crc_err_o  = err_q[E_RD_CRC];
  assign rd_to_err_o   = err_q[E_RD_TO];
  assign wr_crc_err_o  = err_q[E_WR_CRC];
  assign spi_tok_err_o = err_q[E_SPI_TOK];
  assign done_o        = (state_q == ST_DONE);
  assign busy_o        = (state_q == ST_WR_BUSY);
endmodule

// File: rtl/mce_checker.sv
module mce_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_tick_i,
  input logic cmd_start_i,
  input logic err_clr_i,
  input logic rd_byte_vld_i,
  input logic rd_crc_vld_i,
  input logic wr_tok_vld_i,
  input logic rsp_crc_err_o,
  input logic rsp_to_err_o,
  input logic rd_crc_err_o,
  input logic rd_to_err_o,
  input logic wr_crc_err_o,
  input logic spi_tok_err_o,
  input logic done_o,
  input logic busy_o
);
  logic [5:0] errs;
  assign errs = {spi_tok_err_o, wr_crc_err_o, rd_to_err_o, rd_crc_err_o,
                 rsp_to_err_o, rsp_crc_err_o};

  p_start_clears_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_start_i |=> (errs == 6'b0));

  p_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_clr_i && !cmd_start_i) |=> ((errs & $past(errs)) == $past(errs)));

  p_rsp_to_tick_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_to_err_o) |-> $past(bus_tick_i));

  p_rd_to_tick_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_to_err_o) |-> $past(bus_tick_i));

  p_rd_crc_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_crc_err_o) |-> $past(rd_crc_vld_i));

  p_wr_tok_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_crc_err_o) |-> $past(wr_tok_vld_i));

  p_spi_tok_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_tok_err_o) |-> $past(rd_byte_vld_i));

  p_busy_not_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  p_done_holds_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !cmd_start_i) |=> done_o);
endmodule

bind mmc_err_detect mce_checker i_mce_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_tick_i    (bus_tick_i),
  .cmd_start_i   (cmd_start_i),
  .err_clr_i     (err_clr_i),
  .rd_byte_vld_i (rd_byte_vld_i),
  .rd_crc_vld_i  (rd_crc_vld_i),
  .wr_tok_vld_i  (wr_tok_vld_i),
  .rsp_crc_err_o (rsp_crc_err_o),
  .rsp_to_err_o  (rsp_to_err_o),
  .rd_crc_err_o  (rd_crc_err_o),
  .rd_to_err_o   (rd_to_err_o),
  .wr_crc_err_o  (wr_crc_err_o),
  .spi_tok_err_o (spi_tok_err_o),
  .done_o        (done_o),
  .busy_o        (busy_o)
);

// File: tb/test_mmc_err_detect.sv
module test_mmc_err_detect;
  localparam int TO_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic bus_tick = 0, cmd_start = 0, spi_mode = 0, crc_prot = 0, cmd_end = 0;
  logic [1:0] rsp_fmt = 0, xfer = 0;
  logic [TO_W-1:0] rsp_to = 16'd100, rd_to = 16'd100;
  logic rsp_bit_vld = 0, rsp_bit = 1, rsp_byte_vld = 0;
  logic [7:0] rsp_byte = 8'hFF;
  logic rd_start = 0, rd_byte_vld = 0;
  logic [7:0] rd_byte = 8'hFF;
  logic rd_crc_vld = 0, rd_crc_ok = 0, wr_tok_vld = 0;
  logic [2:0] wr_tok = 0;
  logic dat0 = 1, err_clr = 0;
  logic rsp_crc_err, rsp_to_err, rd_crc_err, rd_to_err, wr_crc_err, spi_tok_err, done, busy;

  mmc_err_detect #(.TO_W(TO_W)) i_mmc_err_detect (
    .clk_i(clk), .rst_ni(rst_n), .bus_tick_i(bus_tick), .cmd_start_i(cmd_start),
    .spi_mode_i(spi_mode), .crc_prot_i(crc_prot), .rsp_fmt_i(rsp_fmt), .xfer_i(xfer),
    .cmd_end_i(cmd_end), .rsp_to_i(rsp_to), .rd_to_i(rd_to),
    .rsp_bit_vld_i(rsp_bit_vld), .rsp_bit_i(rsp_bit), .rsp_byte_vld_i(rsp_byte_vld),
    .rsp_byte_i(rsp_byte), .rd_start_i(rd_start), .rd_byte_vld_i(rd_byte_vld),
    .rd_byte_i(rd_byte), .rd_crc_vld_i(rd_crc_vld), .rd_crc_ok_i(rd_crc_ok),
    .wr_tok_vld_i(wr_tok_vld), .wr_tok_i(wr_tok), .dat0_i(dat0), .err_clr_i(err_clr),
    .rsp_crc_err_o(rsp_crc_err), .rsp_to_err_o(rsp_to_err), .rd_crc_err_o(rd_crc_err),
    .rd_to_err_o(rd_to_err), .wr_crc_err_o(wr_crc_err), .spi_tok_err_o(spi_tok_err),
    .done_o(done), .busy_o(busy)
  );

  // flag vector: [0] rsp crc, [1] rsp timeout, [2] rd crc, [3] rd timeout, [4] wr crc, [5] spi token
  logic [5:0] flags;
  assign flags = {spi_tok_err, wr_crc_err, rd_to_err, rd_crc_err, rsp_to_err, rsp_crc_err};

  typedef struct { logic [5:0] vec; string tag; } exp_t;
  exp_t sb_q[$];

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [5:0] v, input string tag);
    exp_t e;
    e.vec = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compares the flag vector each time a sequence finishes
  logic done_prev = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !done_prev) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R14 unexpected done", 32'(flags), 32'h0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(flags == e.vec, e.tag, 32'(flags), 32'(e.vec));
        end
      end
      done_prev <= done;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      bus_tick = 1; step(); bus_tick = 0; step();
    end
  endtask

  task automatic start_cmd(input logic spi, input logic prot, input logic [1:0] fmt, input logic [1:0] xf);
    spi_mode = spi; crc_prot = prot; rsp_fmt = fmt; xfer = xf;
    cmd_start = 1; step(); cmd_start = 0;
    cmd_end = 1; step(); cmd_end = 0;
  endtask

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  task automatic nat_rsp(input bit long_f, input bit bad, input logic [31:0] seed);
    logic [0:135] v;
    logic [6:0] c;
    int last, cb, ce;
    v = '1;
    c = '0;
    last = long_f ? 135 : 47;
    cb = long_f ? 8 : 0;
    ce = long_f ? 128 : 40;
    v[0] = 1'b0; v[1] = 1'b0;
    for (int i = 2; i < ce; i++) v[i] = long_f && i < 8 ? 1'b1 : seed[i % 32] ^ (i % 3 == 0);
    for (int i = cb; i < ce; i++) c = crc_step(c, v[i]);
    for (int i = 0; i < 7; i++) v[ce + i] = c[6 - i];
    if (bad) v[ce + 2] = ~v[ce + 2];
    v[last] = 1'b1;
    for (int i = 0; i <= last; i++) begin
      rsp_bit_vld = 1; rsp_bit = v[i]; bus_tick = 1; step();
      rsp_bit_vld = 0; rsp_bit = 1; bus_tick = 0; step();
    end
  endtask

  task automatic spi_rsp(input logic [7:0] b);
    rsp_byte_vld = 1; rsp_byte = b; bus_tick = 1; step();
    rsp_byte_vld = 0; rsp_byte = 8'hFF; bus_tick = 0; step();
  endtask

  task automatic spi_rd(input logic [7:0] b);
    rd_byte_vld = 1; rd_byte = b; bus_tick = 1; step();
    rd_byte_vld = 0; rd_byte = 8'hFF; bus_tick = 0; step();
  endtask

  task automatic crc_verdict(input logic ok);
    rd_crc_vld = 1; rd_crc_ok = ok; step(); rd_crc_vld = 0; step();
  endtask

  task automatic wr_token(input logic [2:0] t, input int busy_cycles);
    wr_tok_vld = 1; wr_tok = t; dat0 = (busy_cycles == 0); step();
    wr_tok_vld = 0;
    for (int i = 0; i < busy_cycles; i++) step();
    dat0 = 1; step(); step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(flags == 6'b0, "R1 flags after reset", 32'(flags), 0);
    check(done == 1'b0, "R1 done after reset", 32'(done), 0);
    check(busy == 1'b0, "R1 busy after reset", 32'(busy), 0);
    step();

    // R2 native short good / bad
    push(6'b000000, "R2 short good");
    start_cmd(0, 1, 2'd1, 2'd0); nat_rsp(0, 0, 32'hA5C3_1E77); step();
    push(6'b000001, "R2 short bad crc");
    start_cmd(0, 1, 2'd1, 2'd0); nat_rsp(0, 1, 32'h1234_5678); step();
    // R2 native long
    push(6'b000000, "R2 long good");
    start_cmd(0, 1, 2'd2, 2'd0); nat_rsp(1, 0, 32'hDEAD_BEEF); step();
    push(6'b000001, "R2 long bad crc");
    start_cmd(0, 1, 2'd2, 2'd0); nat_rsp(1, 1, 32'h0F0F_3C3C); step();
    // R3 no CRC check on format 3
    push(6'b000000, "R3 nocrc format ignores crc");
    start_cmd(0, 1, 2'd3, 2'd0); nat_rsp(0, 1, 32'h5555_AAAA); step();

    // R5 timeout exact
    rsp_to = 16'd5;
    push(6'b000010, "R5 response timeout");
    start_cmd(0, 1, 2'd1, 2'd0); tick_n(5); step();
    check(done == 1'b1, "R14 done after timeout abort", 32'(done), 1);
    // R5 start on the limiting tick wins
    push(6'b000000, "R5 start on last tick wins");
    start_cmd(0, 1, 2'd1, 2'd0); tick_n(4); nat_rsp(0, 0, 32'h0BAD_F00D); step();

    // R13 no ticks: no timeout
    rsp_to = 16'd3;
    push(6'b000000, "R13 frozen counter");
    start_cmd(0, 1, 2'd1, 2'd0);
    repeat (50) step();
    @(negedge clk);
    check(rsp_to_err == 1'b0 && done == 1'b0, "R13 no timeout without ticks", 32'({rsp_to_err, done}), 0);
    step();
    nat_rsp(0, 0, 32'h7777_1111); step();
    rsp_to = 16'd100;

    // R4 SPI response lengths
    push(6'b000000, "R4 spi one byte");
    start_cmd(1, 1, 2'd1, 2'd0); spi_rsp(8'hFF); spi_rsp(8'hFF); spi_rsp(8'h00); step();
    push(6'b000000, "R4 spi two bytes");
    start_cmd(1, 1, 2'd2, 2'd0); spi_rsp(8'h01);
    @(negedge clk);
    check(done == 1'b0, "R4 not done after first of two bytes", 32'(done), 0);
    step(); spi_rsp(8'h00); step();

    // R4 five bytes then R7 read crc fail
    push(6'b000100, "R7 spi read crc error");
    start_cmd(1, 1, 2'd3, 2'd1);
    for (int i = 0; i < 4; i++) spi_rsp(8'h00);
    @(negedge clk);
    check(done == 1'b0, "R4 not done after four of five bytes", 32'(done), 0);
    step();
    spi_rsp(8'h3C); spi_rd(8'hFF); spi_rd(8'hFE); crc_verdict(0); step();

    // R11 unprotected read crc masked
    push(6'b000000, "R11 unprotected read crc masked");
    start_cmd(1, 0, 2'd1, 2'd1); spi_rsp(8'h00); spi_rd(8'hFE); crc_verdict(0); step();

    // R10 error token
    push(6'b100000, "R10 spi data error token");
    start_cmd(1, 1, 2'd1, 2'd1); spi_rsp(8'h00); spi_rd(8'hFF); spi_rd(8'h08); step();
    @(negedge clk);
    check(spi_tok_err == 1'b1, "R10 token flag held", 32'(spi_tok_err), 1);
    step();

    // R12 cmd start clears; R6 read timeout
    rd_to = 16'd4;
    push(6'b001000, "R6 read timeout");
    start_cmd(0, 1, 2'd1, 2'd1);
    @(negedge clk);
    check(flags == 6'b0, "R12 cmd start clears flags", 32'(flags), 0);
    step();
    nat_rsp(0, 0, 32'h2468_ACE0); tick_n(4); step();
    rd_to = 16'd100;

    // native read good
    push(6'b000000, "R7 native read crc ok");
    start_cmd(0, 1, 2'd1, 2'd1); nat_rsp(0, 0, 32'h1357_9BDF);
    rd_start = 1; step(); rd_start = 0; step(); crc_verdict(1); step();

    // R8/R9 write token error with busy
    push(6'b010000, "R8 write crc status token");
    start_cmd(0, 1, 2'd1, 2'd2); nat_rsp(0, 0, 32'hCAFE_0001);
    wr_tok_vld = 1; wr_tok = 3'b101; dat0 = 0; step(); wr_tok_vld = 0;
    repeat (6) step();
    @(negedge clk);
    check(busy == 1'b1, "R9 busy while line low", 32'(busy), 1);
    check(done == 1'b0, "R9 not done while busy", 32'(done), 0);
    step();
    dat0 = 1; step(); step();
    @(negedge clk);
    check(busy == 1'b0, "R9 busy ends after line high", 32'(busy), 0);

    // R12 sticky then clear
    step(); repeat (10) step();
    @(negedge clk);
    check(wr_crc_err == 1'b1, "R12 flag sticky", 32'(wr_crc_err), 1);
    step();
    err_clr = 1; step(); err_clr = 0;
    @(negedge clk);
    check(flags == 6'b0, "R12 clear pulse", 32'(flags), 0);
    step();

    // R8 good token, R11 unprotected bad token
    push(6'b000000, "R8 accepted token");
    start_cmd(0, 1, 2'd1, 2'd2); nat_rsp(0, 0, 32'h0000_0042); wr_token(3'b010, 3); step();
    push(6'b000000, "R11 unprotected write token masked");
    start_cmd(1, 0, 2'd1, 2'd2); spi_rsp(8'h00); wr_token(3'b101, 2); step();
    push(6'b010000, "R8 spi protected write token");
    start_cmd(1, 1, 2'd1, 2'd2); spi_rsp(8'h00); wr_token(3'b101, 0); step();

    repeat (5) step();
    check(sb_q.size() == 0, "R14 all sequences completed", 32'(sb_q.size()), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule